// File: doc/BRIEF.md
# Low-Memory Hole Remap Translator

The block turns a page number seen by the memory controller (4 KiB units) into a physical page number. Below 4 GiB, the address range between the top of low memory and the 4 GiB line is taken by I/O, so the DRAM behind that hole is shifted up into a remap window. The block tells which region a page falls in. It passes the page through or moves it into the window. It flags any result that lands outside the window.

Three 16-bit configuration values set the geometry: the top of low memory, the remap base and the remap limit. Each one is scaled into page units inside the block, and they do not all use the same scale. A single write port loads them. A query is a page presented with a valid strobe. The answer appears one cycle later, with its own valid strobe and an error flag.

Top module: `hole_remap_xlat`

## Requirements
- R1: After reset, rsp_valid_o, rsp_page_o and rsp_err_o are 0, and all three configuration values are 0.
- R2: rsp_valid_o equals req_valid_i of the previous clock cycle.
- R3: The low threshold is the top-of-low-memory value shifted left by 4. A page below this threshold comes out unchanged, with rsp_err_o low.
- R4: The window base is the remap base value shifted left by 14. A page at or above 0x100000 and below the window base comes out unchanged, with rsp_err_o low.
- R5: Any other page is remapped to (page − low threshold) + window base. The window limit is the remap limit value shifted left by 14. The result is accepted, with rsp_err_o low, when it is below the window limit and fits in 22 bits.
- R6: A remapped result that is not accepted drives rsp_err_o high. In that case rsp_page_o is the low threshold minus one, taken modulo 2^22 (0x3FFFFF when the threshold is 0).
- R7: A write with wr_sel_i = 0 loads the top-of-low-memory value, 1 loads the remap base and 2 loads the remap limit. The value 3 changes nothing. A query in the same cycle as a write uses the old values, and a query in any later cycle uses the new ones.
- R8: While req_valid_i is low, rsp_page_o and rsp_err_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_sel_i | input | 2 | Selects the value to write: 0 top of low memory, 1 remap base, 2 remap limit, 3 none |
| wr_data_i | input | 16 | Value to write |
| req_valid_i | input | 1 | Query strobe |
| req_page_i | input | 22 | Controller page number |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the query |
| rsp_page_o | output | 22 | Physical page number |
| rsp_err_o | output | 1 | Remapped result outside the window |

## Verification
Directed queries are placed on each side of every boundary: the low threshold, the 4 GiB line, the window base and the window limit. These show which region the block chose and whether the remap arithmetic is off by one. Other cases cover a zero threshold and a window base near the top of the register range. These show how the fallback page wraps, and that a remapped result too wide for 22 bits is rejected. Writes issued in the same cycle as a query show which configuration the query used. Idle gaps between queries show that the outputs hold. A long stream of random configurations and pages then runs against a behavioural model that is compared on every clock.

// File: rtl/hole_remap_pkg.sv
package hole_remap_pkg;
  localparam int unsigned PAGE_W_D     = 22;
  localparam int unsigned REG_W_D      = 16;
  localparam int unsigned TOLM_SHIFT_D = 4;
  localparam int unsigned WIN_SHIFT_D  = 14;
  localparam int unsigned HIGH_PAGE_D  = 32'h0010_0000; // first page at 4 GiB

  typedef enum logic [1:0] {
    CFG_TOLM  = 2'd0,
    CFG_BASE  = 2'd1,
    CFG_LIMIT = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_sel_e;

  localparam int unsigned NUM_CFG = 3;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import hole_remap_pkg::*;
#(
  parameter int unsigned REG_W = REG_W_D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] tolm_o,
  output logic [REG_W-1:0] base_o,
  output logic [REG_W-1:0] limit_o
);
  logic [REG_W-1:0] cfg_q [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_q[g] <= '0;
      else if (wr_en_i && (wr_sel_i == 2'(g)))
        cfg_q[g] <= wr_data_i;
    end
  end

  assign tolm_o  = cfg_q[CFG_TOLM];
  assign base_o  = cfg_q[CFG_BASE];
  assign limit_o = cfg_q[CFG_LIMIT];

  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || wr_sel_i == CFG_NONE) |=>
      ($stable(tolm_o) && $stable(base_o) && $stable(limit_o)));
endmodule

// File: rtl/remap_xlat_comb.sv
module remap_xlat_comb
  import hole_remap_pkg::*;
#(
  parameter int unsigned PAGE_W     = PAGE_W_D,
  parameter int unsigned REG_W      = REG_W_D,
  parameter int unsigned TOLM_SHIFT = TOLM_SHIFT_D,
  parameter int unsigned WIN_SHIFT  = WIN_SHIFT_D,
  parameter int unsigned HIGH_PAGE  = HIGH_PAGE_D
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [REG_W-1:0]  tolm_i,
  input  logic [REG_W-1:0]  base_i,
  input  logic [REG_W-1:0]  limit_i,
  output logic [PAGE_W-1:0] page_o,
  output logic              err_o
);
  localparam int unsigned WIDE_W =
    ((REG_W + WIN_SHIFT) > PAGE_W ? (REG_W + WIN_SHIFT) : PAGE_W) + 1;
  localparam logic [WIDE_W-1:0] HIGH_W = WIDE_W'(HIGH_PAGE);

  logic [WIDE_W-1:0] page_w, tolm_w, base_w, limit_w, remap_w;
  logic pass_low, pass_high, in_win, fits;

  always_comb begin
    page_w  = WIDE_W'(page_i);
    tolm_w  = WIDE_W'(tolm_i)  << TOLM_SHIFT;
    base_w  = WIDE_W'(base_i)  << WIN_SHIFT;
    limit_w = WIDE_W'(limit_i) << WIN_SHIFT;
    // page >= tolm whenever this is used, so no underflow
    remap_w = page_w - tolm_w + base_w;
  end

  assign pass_low  = page_w < tolm_w;
  assign pass_high = (page_w >= HIGH_W) && (page_w < base_w);
  assign in_win    = remap_w < limit_w;
  assign fits      = (remap_w >> PAGE_W) == '0;

  always_comb begin
    err_o = 1'b0;
    if (pass_low || pass_high) begin
      page_o = page_i;
    end else if (in_win && fits) begin
      page_o = PAGE_W'(remap_w);
    end else begin
      err_o  = 1'b1;
      page_o = PAGE_W'(tolm_w - WIDE_W'(1));
    end
  end

  // R3/R4: pass-through regions never flag
  always_comb begin
    if (pass_low || pass_high) assert_pass_no_err_R3: assert (!err_o);
  end
endmodule

// File: rtl/hole_remap_xlat.sv
module hole_remap_xlat
  import hole_remap_pkg::*;
#(
  parameter int unsigned PAGE_W     = PAGE_W_D,
  parameter int unsigned REG_W      = REG_W_D,
  parameter int unsigned TOLM_SHIFT = TOLM_SHIFT_D,
  parameter int unsigned WIN_SHIFT  = WIN_SHIFT_D,
  parameter int unsigned HIGH_PAGE  = HIGH_PAGE_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              req_valid_i,
  input  logic [PAGE_W-1:0] req_page_i,
  output logic              rsp_valid_o,
  output logic [PAGE_W-1:0] rsp_page_o,
  output logic              rsp_err_o
);
  logic [REG_W-1:0]  tolm, base, limit;
  logic [PAGE_W-1:0] xl_page;
  logic              xl_err;

  remap_cfg_regs #(.REG_W(REG_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .tolm_o   (tolm),
    .base_o   (base),
    .limit_o  (limit)
  );

  remap_xlat_comb #(
    .PAGE_W    (PAGE_W),
    .REG_W     (REG_W),
    .TOLM_SHIFT(TOLM_SHIFT),
    .WIN_SHIFT (WIN_SHIFT),
    .HIGH_PAGE (HIGH_PAGE)
  ) u_xlat (
    .page_i (req_page_i),
    .tolm_i (tolm),
    .base_i (base),
    .limit_i(limit),
    .page_o (xl_page),
    .err_o  (xl_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_page_o  <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_page_o <= xl_page;
        rsp_err_o  <= xl_err;
      end
    end
  end

  assert_valid_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_idle_lat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(rsp_page_o) && $stable(rsp_err_o)));
  assert_low_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && ((PAGE_W + 1)'(req_page_i) < ((PAGE_W + 1)'(tolm) << TOLM_SHIFT)))
      |=> (rsp_page_o == $past(req_page_i) && !rsp_err_o));
  assert_fallback_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |->
      (rsp_page_o == PAGE_W'(({{PAGE_W{1'b0}}, $past(tolm)} << TOLM_SHIFT) - 1)));
endmodule

// File: tb/sim_hole_remap_xlat.sv
module sim_hole_remap_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic [21:0] req_page = '0;
  logic        rsp_valid;
  logic [21:0] rsp_page;
  logic        rsp_err;

  int checks = 0;
  int errors = 0;

  // reference state
  longint m_tolm = 0, m_base = 0, m_limit = 0;
  logic        e_valid = 1'b0;
  longint      e_page = 0;
  logic        e_err = 1'b0;
  string       e_tag = "R1";

  always #5 clk = ~clk;

  hole_remap_xlat u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_sel_i   (wr_sel),
    .wr_data_i  (wr_data),
    .req_valid_i(req_valid),
    .req_page_i (req_page),
    .rsp_valid_o(rsp_valid),
    .rsp_page_o (rsp_page),
    .rsp_err_o  (rsp_err)
  );

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference: query sees configuration as it was before this edge's write
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tolm = 0; m_base = 0; m_limit = 0;
      e_valid = 0; e_page = 0; e_err = 0; e_tag = "R1";
    end else begin
      longint t, b, l, p, r;
      e_valid = req_valid;
      if (req_valid) begin
        t = m_tolm << 4; b = m_base << 14; l = m_limit << 14; p = req_page;
        if (p < t) begin
          e_page = p; e_err = 0; e_tag = "R3";
        end else if (p >= 64'h100000 && p < b) begin
          e_page = p; e_err = 0; e_tag = "R4";
        end else begin
          r = p - t + b;
          if (r < l && r < (64'd1 << 22)) begin
            e_page = r; e_err = 0; e_tag = "R5";
          end else begin
            e_page = (t - 1) & 64'h3FFFFF; e_err = 1; e_tag = "R6";
          end
        end
        if (wr_en) e_tag = {e_tag, "/R7"};
      end else begin
        e_tag = "R8";
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_tolm = wr_data;
          2'd1: m_base = wr_data;
          2'd2: m_limit = wr_data;
          default: ;
        endcase
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2", "valid", rsp_valid, e_valid);
      check(e_tag, "page", rsp_page, e_page);
      check(e_tag, "err", rsp_err, e_err);
    end
  end

  task automatic cfg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d; req_valid = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic query(input logic [21:0] p);
    @(negedge clk);
    req_valid = 1; req_page = p; wr_en = 0;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #100000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "valid", rsp_valid, 0);
    check("R1", "page", rsp_page, 0);
    check("R1", "err", rsp_err, 0);
    rst_n = 1;
    // R1: zero config -> remap of page 0 lands at 0 >= limit 0 -> fallback
    query(22'h0);
    cfg(2'd0, 16'hC000);  // threshold 0xC0000
    cfg(2'd1, 16'h0040);  // base 0x100000
    cfg(2'd2, 16'h0050);  // limit 0x140000
    query(22'h0);         // R3
    query(22'h0BFFFF);    // R3 edge
    query(22'h0C0000);    // R5 -> 0x100000
    query(22'h0FFFFF);    // R5 -> 0x13FFFF
    query(22'h100000);    // R6 -> 0x140000 hits limit
    cfg(2'd1, 16'h0048);  // base 0x120000
    query(22'h110000);    // R4
    query(22'h11FFFF);    // R4 edge
    query(22'h120000);    // R6
    cfg(2'd2, 16'h0060);  // limit 0x180000
    query(22'h0C0000);    // R5 -> 0x120000
    // R7: write with same-cycle query uses old value
    @(negedge clk);
    req_valid = 1; req_page = 22'h0D0000; wr_en = 1; wr_sel = 2'd0; wr_data = 16'hD800;
    @(negedge clk);
    req_valid = 1; req_page = 22'h0D0000; wr_en = 0;
    @(negedge clk);
    req_valid = 0;
    // R7: select 3 ignored
    cfg(2'd3, 16'h0001);
    query(22'h0D0000);
    // R8: idle gap
    repeat (4) @(negedge clk);
    // R6: zero threshold wraps fallback
    cfg(2'd0, 16'h0000);
    cfg(2'd1, 16'h0000);
    cfg(2'd2, 16'h0000);
    query(22'h000123);
    // R5/R6: result too wide for 22 bits
    cfg(2'd1, 16'hFFFF);
    cfg(2'd2, 16'hFFFF);
    query(22'h000010);
    // random stream
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 7) == 0);
      wr_sel = 2'($urandom_range(0, 3));
      case ($urandom_range(0, 2))
        0: wr_data = 16'($urandom_range(16'h8000, 16'hFFFF));
        1: wr_data = 16'($urandom_range(16'h0040, 16'h00FF));
        default: wr_data = 16'($urandom);
      endcase
      req_valid = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 2))
        0: req_page = 22'($urandom_range(22'h080000, 22'h140000));
        1: req_page = 22'($urandom_range(22'h0F0000, 22'h3FFFFF));
        default: req_page = 22'($urandom);
      endcase
    end
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule